// File: doc/BRIEF.md
# Word-Serial Booth Multiplier

This block multiplies two 20-bit two's complement fractions that arrive one bit per clock. A word time is 20 clocks, and a one-clock sync strobe marks bit 0 of each word. Both operands are sent least significant bit first. Each operand is a signed fraction: bit 19 is the sign, and the value is the integer code times 2^-19.

The unit works as a three-stage word pipeline. In word n, an operand pair shifts in. In word n+1, an iterative radix-2 Booth engine forms the full-width signed product, one multiplier bit per clock. In word n+2, the rounded 20-bit result shifts out LSB first. A new operand pair is accepted in every word, so shift-in, compute and shift-out overlap and the unit never stalls.

The block is driven by a word-serial data path at a fixed rate, so it has no valid/ready handshake. Because every word is accepted unconditionally, there is no back-pressure. The serial streams are aligned only by the sync strobe.

Top module: `booth_serial_mul`

## Requirements
- R1: From reset, `prod_o` is 0. It stays 0 for the first two word times after reset, until the first operand pair's result begins to shift out.
- R2: The bit position is 0 in the clock where `sync_i` is 1 and advances by one each clock. If no sync arrives, it returns to 0 by itself after position 19, so a word sent without a strobe, directly after a synced word, is still framed correctly.
- R3: The product of the operand pair received in word n is driven on `prod_o` during word n+2. Bit k is driven in the clock at position k, LSB first.
- R4: Operands and result are 20-bit two's complement codes. The result approximates the product (code_a × code_b) × 2^-19 of the two signed operand codes.
- R5: The result equals floor((code_a × code_b + 2^18) / 2^19). This means an exact half LSB rounds toward +infinity: 1 × 2^18 gives 1, and -1 × 2^18 gives 0.
- R6: The only unrepresentable case is -1.0 × -1.0 (both codes 0x80000). It saturates to 0x7FFFF.
- R7: Operand pairs presented in consecutive words each produce their own correct result, two words later, with no stall or gap.
- R8: The Booth engine completes all 20 recoding steps before the end of the compute word, so its result is ready when the output register loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_i | input | 1 | Word strobe; high in the clock carrying bit 0 |
| mcand_i | input | 1 | Serial multiplicand, LSB first |
| mplier_i | input | 1 | Serial multiplier, LSB first |
| prod_o | output | 1 | Serial rounded product, LSB first |

## Verification
The bench targets the following cases:
- **Half-LSB rounding ties, with positive and negative sign.** A design that truncates would return 0 and 0xFFFFF instead of 1 and 0.
- **The -1 × -1 overflow.** Without saturation, the result wraps to 0x80000.
- **Extreme operand pairs.** These include most-negative times most-positive and all-ones times all-ones, where a Booth step that forgets to sign-extend the multiplicand produces large errors.
- **Back-to-back words and a word sent without a sync strobe.** These expose a pipeline that stalls, skews by a bit position, or loses framing when the strobe is absent.

// File: rtl/bsm_pkg.sv
package bsm_pkg;

  typedef enum logic [1:0] {
    BOOTH_NOP = 2'd0,
    BOOTH_ADD = 2'd1,
    BOOTH_SUB = 2'd2
  } booth_op_e;

  // Radix-2 recoding of the pair (current bit, previous bit)
  function automatic booth_op_e booth_decode(input logic cur, input logic prev);
    case ({cur, prev})
      2'b01:   return BOOTH_ADD;
      2'b10:   return BOOTH_SUB;
      default: return BOOTH_NOP;
    endcase
  endfunction

endpackage

// File: rtl/bsm_word_timer.sv
module bsm_word_timer #(
  parameter int W  = 20,
  parameter int CW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sync_i,
  output logic [CW-1:0] pos_o,
  output logic          last_o
);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [CW-1:0] cnt_q;

  assign pos_o  = sync_i ? '0 : cnt_q;
  assign last_o = (pos_o == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (last_o) cnt_q <= '0;
    else             cnt_q <= pos_o + CW'(1);
  end

  AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    pos_o <= LAST); // R2
  AST_WORD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (last_o && !sync_i) |=> (pos_o == '0)); // R2
endmodule

// File: rtl/bsm_serial_capture.sv
module bsm_serial_capture #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mcand_i,
  input  logic         mplier_i,
  output logic [W-1:0] mcand_word_o,
  output logic [W-1:0] mplier_word_o
);
  logic [W-1:0] mc_sr, mp_sr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mc_sr <= '0;
      mp_sr <= '0;
    end else begin
      mc_sr <= {mcand_i,  mc_sr[W-1:1]};
      mp_sr <= {mplier_i, mp_sr[W-1:1]};
    end
  end

  // Word as it stands once the bit currently on the pins is included
  assign mcand_word_o  = {mcand_i,  mc_sr[W-1:1]};
  assign mplier_word_o = {mplier_i, mp_sr[W-1:1]};
endmodule

// File: rtl/bsm_booth_engine.sv
module bsm_booth_engine
  import bsm_pkg::*;
#(
  parameter int W  = 20,
  parameter int SW = $clog2(W + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [W-1:0] mc_i,
  input  logic [W-1:0] mp_i,
  output logic [2*W:0] prod_o,
  output logic         done_o
);
  localparam logic [SW-1:0] STEPS = SW'(W);

  logic [W-1:0]  m_q, q_q;
  logic [W:0]    a_q;
  logic          prev_q;
  logic [SW-1:0] step_q;

  logic [W-1:0]  src_m, src_q, nxt_q;
  logic [W:0]    src_a, m_ext, sum, nxt_a;
  logic          src_prev;
  booth_op_e     op;

  always_comb begin
    src_a    = start_i ? '0   : a_q;
    src_q    = start_i ? mp_i : q_q;
    src_m    = start_i ? mc_i : m_q;
    src_prev = start_i ? 1'b0 : prev_q;
    m_ext    = {src_m[W-1], src_m};
    op       = booth_decode(src_q[0], src_prev);
    unique case (op)
      BOOTH_ADD: sum = src_a + m_ext;
      BOOTH_SUB: sum = src_a - m_ext;
      default:   sum = src_a;
    endcase
    nxt_a = {sum[W], sum[W:1]};
    nxt_q = {sum[0], src_q[W-1:1]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_q    <= '0;
      a_q    <= '0;
      q_q    <= '0;
      prev_q <= 1'b0;
      step_q <= STEPS;
    end else if (start_i) begin
      m_q    <= mc_i;
      a_q    <= nxt_a;
      q_q    <= nxt_q;
      prev_q <= src_q[0];
      step_q <= SW'(1);
    end else if (step_q != STEPS) begin
      a_q    <= nxt_a;
      q_q    <= nxt_q;
      prev_q <= src_q[0];
      step_q <= step_q + SW'(1);
    end
  end

  assign done_o = (step_q == STEPS);
  assign prod_o = {a_q, q_q};

  AST_DONE_BY_WORD_END: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> done_o); // R8
  AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && !done_o) |=> (step_q == $past(step_q) + SW'(1))); // R8
endmodule

// File: rtl/bsm_product_shifter.sv
module bsm_product_shifter #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [2*W:0] raw_i,
  output logic         bit_o
);
  localparam int          PW      = 2 * W + 1;
  localparam logic [PW-1:0] HALF    = PW'(1) << (W - 2);
  localparam logic [PW-1:0] SAT_RAW = PW'(1) << (2 * W - 2);
  localparam logic [W-1:0]  MAX_POS = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0]  MIN_NEG = {1'b1, {(W-1){1'b0}}};

  logic [PW-1:0] rnd;
  logic [W+1:0]  scaled;
  logic          ovf_pos, ovf_neg;
  logic [W-1:0]  result, out_sr;

  always_comb begin
    rnd     = raw_i + HALF;
    scaled  = rnd[PW-1:W-1];
    ovf_pos = !scaled[W+1] && (|scaled[W:W-1]);
    ovf_neg =  scaled[W+1] && !(&scaled[W:W-1]);
    if (ovf_pos)      result = MAX_POS;
    else if (ovf_neg) result = MIN_NEG;
    else              result = scaled[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      out_sr <= '0;
    else if (load_i) out_sr <= result;
    else             out_sr <= {1'b0, out_sr[W-1:1]};
  end

  assign bit_o = out_sr[0];

  AST_SATURATE_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && raw_i == SAT_RAW) |=> (out_sr == MAX_POS)); // R6
endmodule

// File: rtl/booth_serial_mul.sv
module booth_serial_mul #(
  parameter int W = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_i,
  input  logic mcand_i,
  input  logic mplier_i,
  output logic prod_o
);
  localparam int CW = $clog2(W);

  logic [CW-1:0] pos;
  logic          word_end;
  logic [W-1:0]  mc_word, mp_word;
  logic [2*W:0]  raw_prod;
  logic          eng_done;

  bsm_word_timer #(.W(W)) u_timer (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_i),
    .pos_o(pos), .last_o(word_end)
  );

  bsm_serial_capture #(.W(W)) u_capture (
    .clk(clk), .rst_n(rst_n), .mcand_i(mcand_i), .mplier_i(mplier_i),
    .mcand_word_o(mc_word), .mplier_word_o(mp_word)
  );

  bsm_booth_engine #(.W(W)) u_engine (
    .clk(clk), .rst_n(rst_n), .start_i(word_end),
    .mc_i(mc_word), .mp_i(mp_word),
    .prod_o(raw_prod), .done_o(eng_done)
  );

  bsm_product_shifter #(.W(W)) u_shifter (
    .clk(clk), .rst_n(rst_n), .load_i(word_end),
    .raw_i(raw_prod), .bit_o(prod_o)
  );

  AST_IDLE_OUT_AFTER_RESET: assert property (@(posedge clk)
    !rst_n |=> !prod_o); // R1
endmodule

// File: tb/booth_serial_mul_bench.sv
`timescale 1ns/1ps
module booth_serial_mul_bench;
  localparam int W = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_i = 1'b0, mcand_i = 1'b0, mplier_i = 1'b0;
  logic prod_o;

  int checks = 0;
  int errors = 0;
  int wn = 0;
  logic [W-1:0] exp_arr [0:63];
  string        tag_arr [0:63];

  always #2.5 clk = ~clk;

  booth_serial_mul #(.W(W)) u_booth_serial_mul (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_i),
    .mcand_i(mcand_i), .mplier_i(mplier_i), .prod_o(prod_o)
  );

  // {multiplicand, multiplier}
  localparam logic [2*W-1:0] VEC [0:9] = '{
    {20'h40000, 20'h40000}, {20'hC0000, 20'h40000},
    {20'h7FFFF, 20'h7FFFF}, {20'h80001, 20'h12345},
    {20'h00000, 20'hABCDE}, {20'hFFFFF, 20'hFFFFF},
    {20'h55555, 20'hAAAAA}, {20'h80000, 20'h7FFFF},
    {20'h3C3C3, 20'h81818}, {20'h00001, 20'h7FFFF}
  };

  function automatic logic [W-1:0] model(input logic [W-1:0] a, input logic [W-1:0] b);
    longint p, r;
    p = longint'(signed'(a)) * longint'(signed'(b));
    r = (p + 64'sd262144) >>> 19;
    if (r > 64'sd524287) r = 64'sd524287;
    return r[W-1:0];
  endfunction

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // One word time: sample the outgoing bit, then drive the incoming bit
  task automatic send_word(input logic [W-1:0] a, input logic [W-1:0] b,
                           input bit with_sync, input string tag);
    logic [W-1:0] got;
    for (int j = 0; j < W; j++) begin
      @(negedge clk);
      got[j]   = prod_o;
      sync_i   = with_sync && (j == 0);
      mcand_i  = a[j];
      mplier_i = b[j];
    end
    if (wn >= 2) check(tag_arr[wn-2], got, exp_arr[wn-2]);
    else         check("R1 idle output before first result", got, '0);
    exp_arr[wn] = model(a, b);
    tag_arr[wn] = tag;
    wn++;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 reset output", {19'd0, prod_o}, '0);

    // R3 R4 R7 R8: back-to-back table words
    for (int i = 0; i < 10; i++)
      send_word(VEC[i][2*W-1:W], VEC[i][W-1:0], 1'b1, "R3 R4 R7 R8 table");

    // R5: half-LSB ties, positive and negative
    send_word(20'h00001, 20'h40000, 1'b1, "R5 tie positive");
    send_word(20'hFFFFF, 20'h40000, 1'b1, "R5 tie negative");
    // R6: -1 x -1 saturates
    send_word(20'h80000, 20'h80000, 1'b1, "R6 saturation");
    // R2: word without sync strobe relies on position wrap
    send_word(20'h12345, 20'h6789A, 1'b0, "R2 no-sync word");
    send_word(20'hFEDCB, 20'h0F0F0, 1'b1, "R2 resync word");
    // flush
    send_word('0, '0, 1'b1, "flush");
    send_word('0, '0, 1'b1, "flush");

    summary();
    $finish;
  end
endmodule